// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-programmed watchdog. A 16-bit count register climbs by one on every prescaled tick and is compared with a 16-bit limit register. The tick comes from one of three tick-enable inputs: the peripheral clock, the real-time clock or an external source. It then passes through a divider that divides by a power of four, from 1 up to 1024. The count only advances while the enable register holds a 1.

Software services the watchdog by writing zero to the count register. If the count sits at the limit when a prescaled tick arrives, the block raises a reset request. That request stays high until a bus reset or until software writes 0 to the enable register.

Software is expected to set the block up in this order:

1. Disable the block.
2. Write the divider field with no source selected.
3. Load the limit.
4. Clear the count.
5. Write the divider field together with one source bit.
6. Enable the block.

Top module: `kick_watchdog`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `reset_req` is low.
- R2: The registers map as follows: offset 0x0 is the limit (16 bits), 0x4 is the enable register (bit 0 only), 0x8 is the count (16 bits) and 0xC is the control register (bits [5:0]). Reserved bits read as 0. Any other offset reads 0, and a write to it changes nothing.
- R3: The count advances by exactly one on each prescaled tick, but only while enable bit 0 is 1. While that bit is 0 the count holds.
- R4: Control bit 0 selects `pclk_tick`, bit 1 selects `rtc_tick` and bit 2 selects `ext_tick`. Pulses on the sources that are not selected have no effect.
- R5: If no source bit is set, or more than one is set, the count does not advance.
- R6: Divider field code k in control bits [5:3], for k from 0 to 5, makes the count advance once per 4^k selected source pulses.
- R7: Divider codes 6 and 7 act as code 5, so the count advances once per 1024 pulses.
- R8: Any write to the count register loads the written value and restarts the divider phase. Writing 0 services the watchdog.
- R9: While enabled, a prescaled tick that finds the count equal to the limit raises `reset_req` on the next clock. The count then holds at the limit.
- R10: `reset_req` is sticky. It clears only on bus reset or on a write of 0 to enable bit 0. Count writes and enable writes of 1 leave it set.
- R11: A limit of 0xFFFF works: the count reaches 0xFFFF without raising the request, and the next tick raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pclk_tick | input | 1 | One-cycle pulse from the peripheral clock source |
| rtc_tick | input | 1 | One-cycle pulse from the real-time clock source |
| ext_tick | input | 1 | One-cycle pulse from the external clock source |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| reset_req | output | 1 | Sticky reset request |

## Verification
The hardest state to reach from the ports is a divider left partway through its cycle when the count register is written. The loss of that partial phase is visible only as one extra tick's worth of pulses. The stimulus selects divide-by-4 and sends three source pulses, which leaves the divider one pulse short of a tick. It then writes the count register and shows that a single further pulse does not move the count, while three more pulses do. The reserved divider codes get a similar treatment: exactly 1023 and then 1024 pulses are sent, so that the tick lands on the expected pulse.

// File: rtl/kick_watchdog_pkg.sv
// Package kick_watchdog_pkg
// Shared widths, the register offset type and derived sizes for the
// prescaled watchdog. Assumes a 4-bit byte-offset bus with word-aligned registers.
package kick_watchdog_pkg;

    parameter int DATA_W  = 16;   // width of count and limit
    parameter int ADDR_W  = 4;    // bus offset width
    parameter int NUM_SRC = 3;    // number of tick sources
    parameter int DIV_W   = 3;    // divider code field width
    parameter int MAX_EXP = 5;    // largest power-of-four exponent

    localparam int CTRL_W  = NUM_SRC + DIV_W;  // implemented control bits
    localparam int PHASE_W = 2 * MAX_EXP;      // divider phase counter width

    // Register byte offsets; the positions are what software decodes.
    typedef enum logic [ADDR_W-1:0] {
        OFS_LIMIT  = 4'h0,
        OFS_ENABLE = 4'h4,
        OFS_COUNT  = 4'h8,
        OFS_CTRL   = 4'hC
    } reg_ofs_e;

endpackage

// File: rtl/kick_watchdog_regs.sv
// Module kick_watchdog_regs
// Holds the limit, enable and control registers. Decodes bus writes into
// the count load strobe and the request-clear strobe, and muxes read data.
// Assumes single-cycle bus accesses. Reads are combinational from bus_addr.
module kick_watchdog_regs
    import kick_watchdog_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] count_val,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] limit_q,
    output logic          run_q,
    output logic [CW-1:0] ctrl_q,
    output logic          count_load,
    output logic          req_clear
);

    logic wr_any;
    logic hit_limit, hit_enable, hit_count, hit_ctrl;

    // Decode which register the current access targets.
    always_comb begin
        wr_any     = bus_en && bus_we;
        hit_limit  = (bus_addr == OFS_LIMIT);
        hit_enable = (bus_addr == OFS_ENABLE);
        hit_count  = (bus_addr == OFS_COUNT);
        hit_ctrl   = (bus_addr == OFS_CTRL);
    end

    // Strobes consumed by the counting core.
    always_comb begin
        count_load = wr_any && hit_count;
        req_clear  = wr_any && hit_enable && !bus_wdata[0];
    end

    // Store the configuration registers on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
            run_q   <= 1'b0;
            ctrl_q  <= '0;
        end else if (wr_any) begin
            if (hit_limit)  limit_q <= bus_wdata;
            if (hit_enable) run_q   <= bus_wdata[0];
            if (hit_ctrl)   ctrl_q  <= bus_wdata[CW-1:0];
        end
    end

    // Read mux; reserved bits and unused offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_limit)       bus_rdata = limit_q;
        else if (hit_enable) bus_rdata[0] = run_q;
        else if (hit_count)  bus_rdata = count_val;
        else if (hit_ctrl)   bus_rdata[CW-1:0] = ctrl_q;
    end

endmodule

// File: rtl/kick_watchdog_prescale.sv
// Module kick_watchdog_prescale
// Gates the tick sources with the one-hot select and divides the chosen
// source by 4^code. Codes above MAX_EXP saturate. Assumes the source inputs
// are single-cycle pulses in the clk domain. An invalid select yields no ticks.
module kick_watchdog_prescale
    import kick_watchdog_pkg::*;
#(
    parameter int NS   = NUM_SRC,
    parameter int DVW  = DIV_W,
    parameter int MEXP = MAX_EXP,
    parameter int PW   = PHASE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NS-1:0]  src_pulse,
    input  logic [NS-1:0]  src_sel,
    input  logic [DVW-1:0] div_code,
    input  logic           run,
    input  logic           phase_clr,
    output logic           pre_tick
);

    localparam logic [PW:0]    ONE_W    = 1;
    localparam logic [DVW-1:0] EXP_SAT  = DVW'(MEXP);

    logic [NS-1:0]  gated;
    logic [1:0]     sel_cnt;
    logic           sel_ok;
    logic           src_hit;
    logic [DVW-1:0] exp_eff;
    logic [PW:0]    span;
    logic [PW-1:0]  terminal;
    logic [PW-1:0]  phase_q;

    // One AND gate per source between its pulse and its select bit.
    for (genvar gi = 0; gi < NS; gi++) begin : g_gate
        assign gated[gi] = src_pulse[gi] & src_sel[gi];
    end

    // Count the set select bits; exactly one is required.
    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < NS; i++) begin
            if (src_sel[i] && sel_cnt != 2'd2) sel_cnt = sel_cnt + 2'd1;
        end
        sel_ok  = (sel_cnt == 2'd1);
        src_hit = sel_ok && (|gated);
    end

    // Saturate the exponent and derive the terminal phase 4^exp - 1.
    always_comb begin
        exp_eff  = (div_code > EXP_SAT) ? EXP_SAT : div_code;
        span     = ONE_W << {exp_eff, 1'b0};
        terminal = PW'(span - ONE_W);
    end

    // A prescaled tick fires when the running phase reaches the terminal.
    always_comb begin
        pre_tick = run && src_hit && (phase_q >= terminal);
    end

    // Advance or restart the divider phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_clr) begin
            phase_q <= '0;
        end else if (run && src_hit) begin
            phase_q <= pre_tick ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/kick_watchdog_core.sv
// Module kick_watchdog_core
// The count register, the limit compare and the sticky reset request.
// Assumes pre_tick already includes the run gating. A bus load beats a
// tick that arrives in the same cycle.
module kick_watchdog_core
    import kick_watchdog_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pre_tick,
    input  logic          count_load,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] limit,
    input  logic          req_clear,
    output logic [DW-1:0] count_q,
    output logic          req_q
);

    logic at_limit;
    logic step;
    logic trip;

    // Classify the current tick as a step or a trip.
    always_comb begin
        at_limit = (count_q == limit);
        step     = run && pre_tick && !count_load && !at_limit;
        trip     = run && pre_tick && !count_load && at_limit;
    end

    // Update the count register.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (count_load) count_q <= load_val;
        else if (step)       count_q <= count_q + 1'b1;
    end

    // Set the sticky request on a trip; clear it on a disable write.
    always_ff @(posedge clk) begin
        if (!rst_n)         req_q <= 1'b0;
        else if (req_clear) req_q <= 1'b0;
        else if (trip)      req_q <= 1'b1;
    end

endmodule

// File: rtl/kick_watchdog.sv
// Module kick_watchdog
// Top of the prescaled watchdog: the register file, the source select with
// its divider, and the counting core. Assumes the tick inputs are
// synchronous one-cycle pulses.
module kick_watchdog
    import kick_watchdog_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pclk_tick,
    input  logic          rtc_tick,
    input  logic          ext_tick,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          reset_req
);

    logic [DW-1:0]      limit_q;
    logic               run_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               count_load;
    logic               req_clear;
    logic               pre_tick;
    logic [DW-1:0]      count_q;
    logic [NUM_SRC-1:0] src_pulse;

    // Gather the tick sources in select-bit order.
    assign src_pulse = {ext_tick, rtc_tick, pclk_tick};

    kick_watchdog_regs #(.DW(DW), .AW(AW), .CW(CTRL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count_val  (count_q),
        .bus_rdata  (bus_rdata),
        .limit_q    (limit_q),
        .run_q      (run_q),
        .ctrl_q     (ctrl_q),
        .count_load (count_load),
        .req_clear  (req_clear)
    );

    kick_watchdog_prescale #(
        .NS(NUM_SRC), .DVW(DIV_W), .MEXP(MAX_EXP), .PW(PHASE_W)
    ) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .src_sel   (ctrl_q[NUM_SRC-1:0]),
        .div_code  (ctrl_q[CTRL_W-1:NUM_SRC]),
        .run       (run_q),
        .phase_clr (count_load),
        .pre_tick  (pre_tick)
    );

    kick_watchdog_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .pre_tick   (pre_tick),
        .count_load (count_load),
        .load_val   (bus_wdata),
        .limit      (limit_q),
        .req_clear  (req_clear),
        .count_q    (count_q),
        .req_q      (reset_req)
    );

endmodule

// File: rtl/kick_watchdog_checker.sv
// Module kick_watchdog_checker
// Temporal properties of the watchdog. It is bound into kick_watchdog and
// watches the bus ports together with the internal count, limit and tick.
module kick_watchdog_checker
    import kick_watchdog_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               reset_req,
    input logic               run_q,
    input logic [DATA_W-1:0]  count_q,
    input logic [DATA_W-1:0]  limit_q,
    input logic [CTRL_W-1:0]  ctrl_q,
    input logic               pre_tick
);

    logic load_wr;
    logic off_wr;
    assign load_wr = bus_en && bus_we && (bus_addr == 4'h8);
    assign off_wr  = bus_en && bus_we && (bus_addr == 4'h4) && !bus_wdata[0];

    // R3: while disabled, and with no load, the count holds.
    assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_wr) |=> $stable(count_q));

    // R3: each tick below the limit adds exactly one.
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && pre_tick && !load_wr && count_q != limit_q)
        |=> (count_q == $past(count_q) + 16'd1));

    // R5: a select that is not one-hot yields no tick.
    assert_no_tick_bad_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$onehot(ctrl_q[NUM_SRC-1:0])) |-> !pre_tick);

    // R8: a count write loads the written value.
    assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (count_q == $past(bus_wdata)));

    // R9: a tick at the limit raises the request.
    assert_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && pre_tick && !load_wr && !off_wr && count_q == limit_q)
        |=> reset_req);

    // R10: the request stays up unless enable is written to 0.
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !off_wr) |=> reset_req);

    // R10: a disable write drops the request.
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr |=> !reset_req);

endmodule

bind kick_watchdog kick_watchdog_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .reset_req (reset_req),
    .run_q     (run_q),
    .count_q   (count_q),
    .limit_q   (limit_q),
    .ctrl_q    (ctrl_q),
    .pre_tick  (pre_tick)
);

// File: tb/kick_watchdog_bench.sv
// Directed bench for kick_watchdog: one task per scenario.
module kick_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ticks = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        reset_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    kick_watchdog u_kick_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .pclk_tick (ticks[0]),
        .rtc_tick  (ticks[1]),
        .ext_tick  (ticks[2]),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reset_req (reset_req)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pulse(input int src, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ticks[src] = 1'b1;
            @(negedge clk); ticks[src] = 1'b0;
        end
    endtask

    task automatic setup(input logic [15:0] lim, input logic [15:0] ctl);
        wr(4'h4, 16'h0000);
        wr(4'hC, ctl & 16'h0038);
        wr(4'h0, lim);
        wr(4'h8, 16'h0000);
        wr(4'hC, ctl);
        wr(4'h4, 16'h0001);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v);
            check("R1", "register after reset", v, 16'h0);
        end
        check("R1", "reset_req after reset", {15'b0, reset_req}, 16'h0);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        wr(4'hC, 16'hFFFF); rd(4'hC, v); check("R2", "control reserved bits", v, 16'h003F);
        wr(4'h4, 16'h00FF); rd(4'h4, v); check("R2", "enable reserved bits", v, 16'h0001);
        wr(4'h0, 16'hA5C3); rd(4'h0, v); check("R2", "limit readback", v, 16'hA5C3);
        wr(4'hC, 16'h0000);
        wr(4'h8, 16'h1234); rd(4'h8, v); check("R2", "count readback", v, 16'h1234);
        wr(4'h2, 16'h5555); rd(4'h2, v); check("R2", "unused offset reads 0", v, 16'h0);
        rd(4'h0, v); check("R2", "limit after stray write", v, 16'hA5C3);
        rd(4'h8, v); check("R2", "count after stray write", v, 16'h1234);
    endtask

    task automatic t_sources();
        logic [15:0] v;
        setup(16'hFFFF, 16'h0001);
        pulse(0, 5); rd(4'h8, v); check("R3", "pclk /1 count", v, 16'd5);
        pulse(1, 3); pulse(2, 3); rd(4'h8, v); check("R4", "unselected sources ignored", v, 16'd5);
        setup(16'hFFFF, 16'h0002);
        pulse(0, 2); pulse(1, 4); rd(4'h8, v); check("R4", "rtc selected", v, 16'd4);
        setup(16'hFFFF, 16'h0004);
        pulse(2, 6); rd(4'h8, v); check("R4", "ext selected", v, 16'd6);
    endtask

    task automatic t_bad_select();
        logic [15:0] v;
        setup(16'hFFFF, 16'h0003);
        pulse(0, 4); pulse(1, 4); rd(4'h8, v); check("R5", "two sources selected", v, 16'd0);
        wr(4'hC, 16'h0000);
        pulse(0, 4); rd(4'h8, v); check("R5", "no source selected", v, 16'd0);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        setup(16'hFFFF, 16'h0009);
        pulse(0, 3); rd(4'h8, v); check("R6", "/4 after 3 pulses", v, 16'd0);
        pulse(0, 1); rd(4'h8, v); check("R6", "/4 after 4 pulses", v, 16'd1);
        setup(16'hFFFF, 16'h0011);
        pulse(0, 31); rd(4'h8, v); check("R6", "/16 after 31 pulses", v, 16'd1);
        pulse(0, 1); rd(4'h8, v); check("R6", "/16 after 32 pulses", v, 16'd2);
        setup(16'hFFFF, 16'h0019);
        pulse(0, 64); rd(4'h8, v); check("R6", "/64 after 64 pulses", v, 16'd1);
    endtask

    task automatic t_reserved_div();
        logic [15:0] v;
        setup(16'hFFFF, 16'h0031);
        pulse(0, 1023); rd(4'h8, v); check("R7", "code 6 after 1023 pulses", v, 16'd0);
        pulse(0, 1); rd(4'h8, v); check("R7", "code 6 after 1024 pulses", v, 16'd1);
        setup(16'hFFFF, 16'h0039);
        pulse(0, 1024); rd(4'h8, v); check("R7", "code 7 after 1024 pulses", v, 16'd1);
    endtask

    task automatic t_kick_phase();
        logic [15:0] v;
        setup(16'hFFFF, 16'h0009);
        pulse(0, 3);
        wr(4'h8, 16'd5);
        pulse(0, 1); rd(4'h8, v); check("R8", "phase restarted by load", v, 16'd5);
        pulse(0, 3); rd(4'h8, v); check("R8", "tick after full phase", v, 16'd6);
        wr(4'h8, 16'd0); rd(4'h8, v); check("R8", "kick clears count", v, 16'd0);
    endtask

    task automatic t_compare();
        logic [15:0] v;
        setup(16'd3, 16'h0001);
        pulse(0, 3); rd(4'h8, v); check("R9", "count at limit", v, 16'd3);
        check("R9", "no request before trip", {15'b0, reset_req}, 16'd0);
        pulse(0, 1);
        check("R9", "request after trip", {15'b0, reset_req}, 16'd1);
        pulse(0, 2); rd(4'h8, v); check("R9", "count holds at limit", v, 16'd3);
        wr(4'h8, 16'd0);
        check("R10", "request survives kick", {15'b0, reset_req}, 16'd1);
        pulse(0, 1); rd(4'h8, v); check("R10", "count runs after kick", v, 16'd1);
        wr(4'h4, 16'h0001);
        check("R10", "request survives enable=1", {15'b0, reset_req}, 16'd1);
        wr(4'h4, 16'h0000);
        check("R10", "request cleared by disable", {15'b0, reset_req}, 16'd0);
        pulse(0, 2); rd(4'h8, v); check("R3", "disabled count holds", v, 16'd1);
    endtask

    task automatic t_full_range();
        logic [15:0] v;
        setup(16'hFFFF, 16'h0001);
        wr(4'h8, 16'hFFFE);
        pulse(0, 1); rd(4'h8, v); check("R11", "count reaches FFFF", v, 16'hFFFF);
        check("R11", "no request at FFFF", {15'b0, reset_req}, 16'd0);
        pulse(0, 1);
        check("R11", "request after FFFF tick", {15'b0, reset_req}, 16'd1);
        rd(4'h8, v); check("R11", "count holds FFFF", v, 16'hFFFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_sources();
        t_bad_select();
        t_prescale();
        t_reserved_div();
        t_kick_phase();
        t_compare();
        t_full_range();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule